// File: doc/BRIEF.md
# Cascaded VGA Sync Timing Generator

This block produces the horizontal and vertical synchronisation pulses for a 640x480-class raster from a single pixel-rate clock. A horizontal position counter advances on every clock and wraps once per line. Each wrap moves a vertical line counter forward by one, so the line counter never sees the pixel clock directly. With the default timing and a pixel clock of about 23.86 MHz, the line rate is about 29.82 kHz and the frame rate is about 60 Hz.

Both sync pulses are active low. Each begins at the zero point of its counter and lasts for the sync end minus the sync start of the modeline: 64 pixel clocks for the horizontal pulse and 3 lines for the vertical pulse. A separate compare on the horizontal position raises a one-clock scanout strobe at a chosen pixel of every line. A downstream serializer uses that strobe to start sending a line. The line number output is captured at the same moment, so the serializer knows which line it is starting.

The enable input starts and stops the raster. While enable is low, the counters are held at zero and the block is idle. The first clock edge that samples enable high starts the frame at pixel 0 of line 0.

Top module: `vga_sync_gen`

## Requirements
- R1: During and just after reset, `hsync_n` and `vsync_n` are 1, `scan_stb` is 0 and `line_o` is 0.
- R2: While `en` is sampled low, both counters are held at zero, `hsync_n` and `vsync_n` stay 1 and `scan_stb` stays 0. `line_o` keeps its last value.
- R3: The first rising edge that samples `en` high enters pixel 0 of line 0. Each further enabled edge advances the pixel position by one. After pixel H_TOTAL-1 the position returns to 0, so a line lasts H_TOTAL clocks.
- R4: `hsync_n` is 0 exactly while the pixel position is below H_SYNC_END-H_SYNC_START (64 by default), and 1 otherwise.
- R5: The line counter advances only on the edge where the pixel position wraps from H_TOTAL-1 to 0. After line V_TOTAL-1 it returns to 0, so a frame lasts H_TOTAL*V_TOTAL clocks.
- R6: `vsync_n` is 0 exactly while the line is below V_SYNC_END-V_SYNC_START (3 by default), and 1 otherwise.
- R7: `scan_stb` is 1 for exactly one clock per line, while the pixel position equals SCAN_POS (90 by default). This holds on every line, including the lines in the vertical sync pulse.
- R8: `line_o` takes the current line number in the same cycle that `scan_stb` is 1, and holds that value until the next strobe.
- R9: If `en` goes low in the middle of a frame and later returns high, the raster restarts at pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Runs the raster while high; holds it at zero while low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| scan_stb | output | 1 | One-clock scanout-start strobe, once per line |
| line_o | output | clog2(V_TOTAL) | Line number captured at the scanout strobe |

## Verification
The hardest situations to reach from the ports are the ones that happen only once per frame:
- the line counter wrapping back to zero;
- the scanout strobe landing on the last pixel of a line, in the same cycle as the vertical step;
- enable being dropped in the middle of a frame.

The bench uses a small modeline: 12 clocks per line, 5 lines per frame, and the strobe on the last pixel. With this modeline, several whole frames and every wrap fit into a few hundred cycles. A reference model computes the pixel position and line number arithmetically from the number of enabled edges. The bench compares every output on every cycle against that model, before and after an enable drop in the middle of a frame.

// File: rtl/vga_sync_pkg.sv
package vga_sync_pkg;

  // Width of a sync pulse, in counts, from its start and end positions.
  function automatic int pulse_span(input int start_pos, input int end_pos);
    return end_pos - start_pos;
  endfunction

endpackage

// File: rtl/vga_axis_counter.sv
// One raster axis: a wrapping position counter plus a registered active-low
// pulse that covers the first PULSE counts of each period.
module vga_axis_counter #(
  parameter int TOTAL = 800,
  parameter int PULSE = 64,
  localparam int W = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         step,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic         wrap_o,
  output logic         sync_n_o
);

  localparam logic [W-1:0] LAST = W'(TOTAL - 1);
  localparam logic [W-1:0] PW   = W'(PULSE);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         sync_n_q;
  logic         sync_n_d;
  logic         wrap;

  // next state
  always_comb begin
    wrap = step && (cnt_q == LAST);
    if (!en) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    sync_n_d = !(en && (cnt_d < PW));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sync_n_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_d;
      sync_n_q <= sync_n_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;
  assign wrap_o    = wrap;
  assign sync_n_o  = sync_n_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wrap) |=> (cnt_q == '0));

  // R4
  pulse_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n_q |-> (cnt_q < PW));

endmodule

// File: rtl/vga_scan_trigger.sv
// Per-line scanout strobe and the line number captured with it.
module vga_scan_trigger #(
  parameter int H_W      = 10,
  parameter int V_W      = 9,
  parameter int SCAN_POS = 90
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [H_W-1:0] h_nxt,
  input  logic [V_W-1:0] v_nxt,
  output logic           stb_o,
  output logic [V_W-1:0] line_o
);

  localparam logic [H_W-1:0] SP = H_W'(SCAN_POS);

  logic           hit;
  logic           stb_q;
  logic [V_W-1:0] line_q;
  logic [V_W-1:0] line_d;

  // next state
  always_comb begin
    hit    = en && (h_nxt == SP);
    line_d = hit ? v_nxt : line_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= 1'b0;
      line_q <= '0;
    end else begin
      stb_q  <= hit;
      line_q <= line_d;
    end
  end

  assign stb_o  = stb_q;
  assign line_o = line_q;

  // R7
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R8
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(line_q));

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen #(
  parameter int H_SYNC_START = 656,
  parameter int H_SYNC_END   = 720,
  parameter int H_TOTAL      = 800,
  parameter int V_SYNC_START = 481,
  parameter int V_SYNC_END   = 484,
  parameter int V_TOTAL      = 497,
  parameter int SCAN_POS     = 90,
  localparam int LINE_W      = $clog2(V_TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              scan_stb,
  output logic [LINE_W-1:0] line_o
);

  import vga_sync_pkg::*;

  localparam int H_W   = $clog2(H_TOTAL);
  localparam int V_W   = LINE_W;
  localparam int H_PW  = pulse_span(H_SYNC_START, H_SYNC_END);
  localparam int V_PW  = pulse_span(V_SYNC_START, V_SYNC_END);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // run flag: the first enabled edge parks the raster at pixel 0, line 0
  logic run_q;
  logic run_d;

  always_comb run_d = en;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) run_q <= 1'b0;
    else             run_q <= run_d;
  end

  logic [H_W-1:0] h_cnt;
  logic [H_W-1:0] h_nxt;
  logic           h_wrap;
  logic [V_W-1:0] v_cnt;
  logic [V_W-1:0] v_nxt;
  logic           v_wrap;

  vga_axis_counter #(.TOTAL(H_TOTAL), .PULSE(H_PW)) u_hcnt (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .en        (en),
    .step      (run_q),
    .cnt_o     (h_cnt),
    .cnt_nxt_o (h_nxt),
    .wrap_o    (h_wrap),
    .sync_n_o  (hsync_n)
  );

  vga_axis_counter #(.TOTAL(V_TOTAL), .PULSE(V_PW)) u_vcnt (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .en        (en),
    .step      (h_wrap),
    .cnt_o     (v_cnt),
    .cnt_nxt_o (v_nxt),
    .wrap_o    (v_wrap),
    .sync_n_o  (vsync_n)
  );

  vga_scan_trigger #(.H_W(H_W), .V_W(V_W), .SCAN_POS(SCAN_POS)) u_scan (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .en     (en),
    .h_nxt  (h_nxt),
    .v_nxt  (v_nxt),
    .stb_o  (scan_stb),
    .line_o (line_o)
  );

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !en |=> (hsync_n && vsync_n && !scan_stb && h_cnt == '0 && v_cnt == '0));

  // R5
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (en && run_q && h_cnt != H_LAST) |=> $stable(v_cnt));

  // R5
  v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    v_wrap |-> h_wrap);

  // R8
  line_cap_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    scan_stb |-> (line_o == v_cnt));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (en && !run_q) |=> (h_cnt == '0 && v_cnt == '0));

endmodule

// File: tb/sim_vga_sync_gen.sv
`timescale 1ns/1ps
module sim_vga_sync_gen;

  localparam int HT  = 12;
  localparam int HSS = 9;
  localparam int HSE = 11;
  localparam int VT  = 5;
  localparam int VSS = 3;
  localparam int VSE = 5;
  localparam int SP  = 11;
  localparam int HSW = HSE - HSS;
  localparam int VSW = VSE - VSS;
  localparam int LW  = $clog2(VT);

  logic          clk;
  logic          rst_n;
  logic          en;
  logic          hsync_n;
  logic          vsync_n;
  logic          scan_stb;
  logic [LW-1:0] line_o;

  int checks;
  int failures;
  int cycles;
  bit done;

  // reference model state
  bit m_run;
  int m_t;
  int m_line;

  vga_sync_gen #(
    .H_SYNC_START(HSS), .H_SYNC_END(HSE), .H_TOTAL(HT),
    .V_SYNC_START(VSS), .V_SYNC_END(VSE), .V_TOTAL(VT),
    .SCAN_POS(SP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .scan_stb(scan_stb), .line_o(line_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, got, exp, cycles);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Drive en for one edge, advance the model, sample at the falling edge.
  task automatic step(input bit e, input string tag);
    int p;
    int l;
    en = e;
    @(posedge clk);
    cycles++;
    if (!e) begin
      m_run = 1'b0;
    end else if (!m_run) begin
      m_run = 1'b1;
      m_t   = 0;
    end else begin
      m_t++;
    end
    @(negedge clk);
    if (!m_run) begin
      // R2
      check({tag, " R2 hsync idle"}, hsync_n, 1);
      check({tag, " R2 vsync idle"}, vsync_n, 1);
      check({tag, " R2 strobe idle"}, scan_stb, 0);
      check({tag, " R2 line held"}, line_o, m_line);
    end else begin
      p = m_t % HT;
      l = (m_t / HT) % VT;
      if (p == SP) m_line = l;
      // R3 R4
      check({tag, " R4 R3 hsync"}, hsync_n, (p < HSW) ? 0 : 1);
      // R5 R6
      check({tag, " R6 R5 vsync"}, vsync_n, (l < VSW) ? 0 : 1);
      // R7
      check({tag, " R7 strobe"}, scan_stb, (p == SP) ? 1 : 0);
      // R8
      check({tag, " R8 line"}, line_o, m_line);
    end
  endtask

  initial begin
    checks   = 0;
    failures = 0;
    cycles   = 0;
    done     = 1'b0;
    m_run    = 1'b0;
    m_t      = 0;
    m_line   = 0;
    en       = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 hsync reset", hsync_n, 1);
    check("R1 vsync reset", vsync_n, 1);
    check("R1 strobe reset", scan_stb, 0);
    check("R1 line reset", line_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step(1'b0, "idle");
    // R3 R5: run over several frames, including line wraps
    for (int i = 0; i < 2 * HT * VT + 37; i++) step(1'b1, "run");
    // R9: drop enable mid-frame, then resume
    for (int i = 0; i < 3; i++) step(1'b0, "R9 stop");
    for (int i = 0; i < HT * VT + 15; i++) step(1'b1, "R9 resume");
    step(1'b0, "tail");
    finish_run();
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule